// File: doc/BRIEF.md
# Host Indirect RAM Access Port

This block gives a host CPU a window of four 16-bit register slots. Through these slots the host reaches two memories on a communication board. One is the program RAM of a coprocessor. The other is the shared communication RAM. The host first writes a control word, then a byte offset. After that it reads or writes the data slot. Each data access moves one 16-bit word and then advances the offset by two bytes, so a block of words can be streamed through a single slot.

The control word has two more jobs. Bit 0 picks which memory the data slot reaches. Bit 5 is the run enable for the coprocessor. The block turns the remaining control bits into level outputs for the surrounding board. The RAM arrays sit outside this block and are assumed to be synchronous: a read issued in one cycle returns its word in the next cycle.

Top module: `hostwin_port`

## Requirements
- R1: After reset the control word and the offset are both 0. `coprocReset` is 1. `bankHint`, `dmaDisable`, `devDisable`, `hostRvalid`, `memRe` and `memWe` are all 0.
- R2: The slot number on `hostIdx` selects a register: 0 is control, 1 is offset, 2 is data and 3 is status. A read pulses `hostRvalid` for one cycle, in the cycle after the request. `hostRdata` carries the value in that same cycle. Control and offset read back their current values.
- R3: During a data access `memSelProg` equals control bit 0. A value of 0 targets the communication RAM and 1 targets the coprocessor program RAM.
- R4: `coprocReset` is the inverse of control bit 5. It takes its new value in the cycle after a control write.
- R5: Control bit 1 drives `bankHint`. Bit 14 drives `dmaDisable`, which turns off bus-master DMA. Bit 15 drives `devDisable`. Each output follows its bit from the cycle after the control write.
- R6: A data write pulses `memWe` in the same cycle as the request. In that cycle `memAddr` equals the offset divided by 2 and `memWdata` equals `hostWdata`. A data read pulses `memRe` with the same address.
- R7: Every data read or write adds 2 to the offset after the access. A read of the offset slot returns the incremented value.
- R8: The offset wraps modulo the 64K-byte window. 0xFFFE becomes 0x0000 and 0xFFFF becomes 0x0001.
- R9: A data read returns the word that the memory presents on `memRdata` in the response cycle.
- R10: A write to the status slot changes no state. A read of the status slot returns the constant `STATUS_WORD`, which defaults to 0x0005.
- R11: When `hostWr` and `hostRd` are both high, only the write is performed. No read response follows.
- R12: `memRe` and `memWe` are never high unless the request addresses the data slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostRd | input | 1 | Host read request |
| hostWr | input | 1 | Host write request |
| hostIdx | input | 2 | Register slot number |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data, valid when `hostRvalid` is high |
| hostRvalid | output | 1 | Read response strobe |
| memRe | output | 1 | Memory read strobe |
| memWe | output | 1 | Memory write strobe |
| memSelProg | output | 1 | 1 selects program RAM, 0 selects communication RAM |
| memAddr | output | 15 | Word address into the selected memory |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data, one cycle after `memRe` |
| coprocReset | output | 1 | Holds the coprocessor in reset when high |
| bankHint | output | 1 | Bank hint level |
| dmaDisable | output | 1 | Bus-master DMA disabled when high |
| devDisable | output | 1 | Device disabled when high |

## Verification
The bench streams words into both memories and reads them back. A design that ignored bit 0 or latched it at the wrong time would return data from the other memory. A design whose address ran one step ahead would write every word to its neighbour. The bench runs the offset across the top of the window, from both an even and an odd start, so an increment that saturated or dropped the low bit would show a wrong readback. It also writes the status slot, issues simultaneous read and write requests, and writes a run bit that is then cleared, which exposes designs that decode slot 3 as control, answer the lost read, or hold the coprocessor reset level.

// File: rtl/hostwin_pkg.sv
package hostwin_pkg;

  typedef enum logic [1:0] {
    SLOT_CTRL = 2'd0,
    SLOT_OFFS = 2'd1,
    SLOT_DATA = 2'd2,
    SLOT_STAT = 2'd3
  } slot_e;

  // control word bit positions
  localparam int CB_PROGSEL = 0;
  localparam int CB_BANK    = 1;
  localparam int CB_RUN     = 5;
  localparam int CB_NODMA   = 14;
  localparam int CB_OFF     = 15;

  typedef struct packed {
    logic  wrCtrl;
    logic  wrOffs;
    logic  dataWr;
    logic  dataRd;
    logic  regRd;
    slot_e rdSlot;
  } strobe_t;

endpackage

// File: rtl/hostwin_ctrl.sv
module hostwin_ctrl
  import hostwin_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostRd,
  input  logic       hostWr,
  input  logic [1:0] hostIdx,
  output strobe_t    stb,
  output logic       hostRvalid,
  output logic       dataPending
);

  slot_e slot;
  logic  rdEn;

  assign slot = slot_e'(hostIdx);
  assign rdEn = hostRd && !hostWr;   // a write wins over a read

  always_comb begin
    stb        = '0;
    stb.rdSlot = slot;
    stb.wrCtrl = hostWr && (slot == SLOT_CTRL);
    stb.wrOffs = hostWr && (slot == SLOT_OFFS);
    stb.dataWr = hostWr && (slot == SLOT_DATA);
    stb.dataRd = rdEn   && (slot == SLOT_DATA);
    stb.regRd  = rdEn   && (slot != SLOT_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRvalid  <= 1'b0;
      dataPending <= 1'b0;
    end else begin
      hostRvalid  <= rdEn;
      dataPending <= stb.dataRd;
    end
  end

  AST_WR_BEATS_RD: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostRd) |=> !hostRvalid);  // R11

endmodule

// File: rtl/hostwin_dp.sv
module hostwin_dp
  import hostwin_pkg::*;
#(
  parameter int          DATA_W      = 16,
  parameter int          ADDR_W      = 16,
  parameter int unsigned STATUS_WORD = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              dataPending,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              memRe,
  output logic              memWe,
  output logic              memSelProg,
  output logic [ADDR_W-2:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              coprocReset,
  output logic              bankHint,
  output logic              dmaDisable,
  output logic              devDisable
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  logic [DATA_W-1:0] ctrlReg;
  logic [ADDR_W-1:0] offsReg;
  logic [DATA_W-1:0] regRdata;
  logic [DATA_W-1:0] offsWide;
  logic [DATA_W-1:0] regMux;

  always_comb begin
    offsWide              = '0;
    offsWide[ADDR_W-1:0]  = offsReg;
  end

  always_comb begin
    case (stb.rdSlot)
      SLOT_CTRL: regMux = ctrlReg;
      SLOT_OFFS: regMux = offsWide;
      default:   regMux = DATA_W'(STATUS_WORD);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      offsReg  <= '0;
      regRdata <= '0;
    end else begin
      if (stb.wrCtrl) ctrlReg <= hostWdata;
      if (stb.wrOffs)
        offsReg <= hostWdata[ADDR_W-1:0];
      else if (stb.dataWr || stb.dataRd)
        offsReg <= offsReg + STEP;          // wraps modulo window
      if (stb.regRd) regRdata <= regMux;
    end
  end

  assign hostRdata   = dataPending ? memRdata : regRdata;
  assign memWe       = stb.dataWr;
  assign memRe       = stb.dataRd;
  assign memAddr     = offsReg[ADDR_W-1:1];
  assign memWdata    = hostWdata;
  assign memSelProg  = ctrlReg[CB_PROGSEL];
  assign coprocReset = !ctrlReg[CB_RUN];
  assign bankHint    = ctrlReg[CB_BANK];
  assign dmaDisable  = ctrlReg[CB_NODMA];
  assign devDisable  = ctrlReg[CB_OFF];

  AST_OFFS_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dataWr || stb.dataRd) |=> offsReg == $past(offsReg) + STEP);  // R7

  AST_RUN_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCtrl |=> coprocReset == !$past(hostWdata[CB_RUN]));  // R4

endmodule

// File: rtl/hostwin_port.sv
module hostwin_port
  import hostwin_pkg::*;
#(
  parameter int          DATA_W      = 16,
  parameter int          ADDR_W      = 16,
  parameter int unsigned STATUS_WORD = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [1:0]        hostIdx,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostRvalid,
  output logic              memRe,
  output logic              memWe,
  output logic              memSelProg,
  output logic [ADDR_W-2:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              coprocReset,
  output logic              bankHint,
  output logic              dmaDisable,
  output logic              devDisable
);

  strobe_t stb;
  logic    dataPending;

  hostwin_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostRd(hostRd), .hostWr(hostWr),
    .hostIdx(hostIdx), .stb(stb), .hostRvalid(hostRvalid),
    .dataPending(dataPending)
  );

  hostwin_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STATUS_WORD(STATUS_WORD)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dataPending(dataPending),
    .hostWdata(hostWdata), .memRdata(memRdata), .hostRdata(hostRdata),
    .memRe(memRe), .memWe(memWe), .memSelProg(memSelProg), .memAddr(memAddr),
    .memWdata(memWdata), .coprocReset(coprocReset), .bankHint(bankHint),
    .dmaDisable(dmaDisable), .devDisable(devDisable)
  );

  AST_MEM_ONLY_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || memRe) |-> hostIdx == SLOT_DATA);  // R12

  AST_STAT_WRITE_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostIdx == SLOT_STAT) |=>
      (coprocReset == $past(coprocReset) && memAddr == $past(memAddr)
       && memSelProg == $past(memSelProg)));  // R10

endmodule

// File: tb/hostwin_port_tb_top.sv
`timescale 1ns/1ps
module hostwin_port_tb_top;

  localparam real CLK_NS = 4.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostRd = 1'b0, hostWr = 1'b0;
  logic [1:0]  hostIdx = 2'd0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic        hostRvalid, memRe, memWe, memSelProg;
  logic [14:0] memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdataQ = '0;
  logic        coprocReset, bankHint, dmaDisable, devDisable;

  always #(CLK_NS/2) clk = ~clk;

  hostwin_port dut_i (
    .clk(clk), .rstN(rstN), .hostRd(hostRd), .hostWr(hostWr), .hostIdx(hostIdx),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostRvalid(hostRvalid),
    .memRe(memRe), .memWe(memWe), .memSelProg(memSelProg), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdataQ), .coprocReset(coprocReset),
    .bankHint(bankHint), .dmaDisable(dmaDisable), .devDisable(devDisable)
  );

  // environment memories (synchronous read)
  logic [15:0] envComm[int];
  logic [15:0] envProg[int];
  always @(posedge clk) begin
    if (memWe) begin
      if (memSelProg) envProg[int'(memAddr)] = memWdata;
      else            envComm[int'(memAddr)] = memWdata;
    end
    if (memRe) begin
      if (memSelProg) memRdataQ <= envProg.exists(int'(memAddr)) ? envProg[int'(memAddr)] : 16'h0;
      else            memRdataQ <= envComm.exists(int'(memAddr)) ? envComm[int'(memAddr)] : 16'h0;
    end
  end

  // reference model
  int          refCtrl = 0;
  int          refOffs = 0;
  logic [15:0] refComm[int];
  logic [15:0] refProg[int];
  int          nChk = 0, nBad = 0;

  function automatic logic [15:0] refRead(int sel, int wordAddr);
    if (sel != 0) return refProg.exists(wordAddr) ? refProg[wordAddr] : 16'h0;
    return refComm.exists(wordAddr) ? refComm[wordAddr] : 16'h0;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic outChk(string tag);
    chk(coprocReset == !refCtrl[5], tag, "coprocReset", int'(coprocReset), int'(!refCtrl[5]));
    chk(bankHint == refCtrl[1], tag, "bankHint", int'(bankHint), refCtrl[1]);
    chk(dmaDisable == refCtrl[14], tag, "dmaDisable", int'(dmaDisable), refCtrl[14]);
    chk(devDisable == refCtrl[15], tag, "devDisable", int'(devDisable), refCtrl[15]);
  endtask

  // one host cycle; entered and left at a falling edge
  task automatic step(bit rd, bit wr, int idx, int wd, string tag);
    bit isData, expWe, expRe, expRv;
    int expRd;
    hostRd = rd; hostWr = wr; hostIdx = idx[1:0]; hostWdata = wd[15:0];
    #0.5;
    isData = (idx == 2);
    expWe  = wr && isData;
    expRe  = rd && !wr && isData;
    chk(memWe == expWe, tag, "memWe", int'(memWe), int'(expWe));
    chk(memRe == expRe, tag, "memRe", int'(memRe), int'(expRe));
    if (expWe || expRe) begin
      chk(int'(memAddr) == refOffs / 2, tag, "memAddr", int'(memAddr), refOffs / 2);
      chk(memSelProg == refCtrl[0], tag, "memSelProg", int'(memSelProg), refCtrl[0]);
    end
    if (expWe) chk(memWdata == wd[15:0], tag, "memWdata", int'(memWdata), wd);
    @(posedge clk);
    expRv = rd && !wr;
    case (idx)
      0: expRd = refCtrl;
      1: expRd = refOffs;
      2: expRd = int'(refRead(refCtrl[0], refOffs / 2));
      default: expRd = 5;
    endcase
    if (wr) begin
      case (idx)
        0: refCtrl = wd & 16'hFFFF;
        1: refOffs = wd & 16'hFFFF;
        2: begin
             if (refCtrl[0]) refProg[refOffs / 2] = wd[15:0];
             else            refComm[refOffs / 2] = wd[15:0];
             refOffs = (refOffs + 2) % 65536;
           end
        default: ;
      endcase
    end else if (rd && isData) begin
      refOffs = (refOffs + 2) % 65536;
    end
    @(negedge clk);
    chk(hostRvalid == expRv, tag, "hostRvalid", int'(hostRvalid), int'(expRv));
    if (expRv) chk(int'(hostRdata) == expRd, tag, "hostRdata", int'(hostRdata), expRd);
    outChk(tag);
    hostRd = 1'b0; hostWr = 1'b0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk(hostRvalid == 1'b0, "R1", "hostRvalid", int'(hostRvalid), 0);
    chk(memWe == 1'b0 && memRe == 1'b0, "R1", "memStrobes", int'({memWe, memRe}), 0);
    outChk("R1");
    step(1, 0, 1, 0, "R1");          // offset reads 0
    step(1, 0, 0, 0, "R2");          // control reads 0
    // R4 run release then re-hold; R5 flag bits
    step(0, 1, 0, 16'h0020, "R4");
    step(1, 0, 0, 0, "R2");
    step(0, 1, 0, 16'hC002, "R5");
    step(0, 1, 0, 16'h4000, "R5");
    step(0, 1, 0, 16'h0000, "R4");
    // R6 write three words into communication RAM
    step(0, 1, 1, 16'h0010, "R6");
    step(0, 1, 2, 16'h1111, "R6");
    step(0, 1, 2, 16'h2222, "R6");
    step(0, 1, 2, 16'h3333, "R6");
    step(1, 0, 1, 0, "R7");          // 0x16
    // R3 same offsets into program RAM
    step(0, 1, 0, 16'h0021, "R3");
    step(0, 1, 1, 16'h0010, "R3");
    step(0, 1, 2, 16'hAAAA, "R3");
    step(0, 1, 2, 16'hBBBB, "R3");
    // R9 read back both memories
    step(0, 1, 0, 16'h0000, "R3");
    step(0, 1, 1, 16'h0010, "R9");
    for (int i = 0; i < 3; i++) step(1, 0, 2, 0, "R9");
    step(0, 1, 0, 16'h0001, "R3");
    step(0, 1, 1, 16'h0010, "R9");
    step(1, 0, 2, 0, "R9");
    step(1, 0, 2, 0, "R9");
    step(1, 0, 2, 0, "R9");          // unwritten word reads 0
    step(1, 0, 1, 0, "R7");
    // R8 wrap from even and odd starts
    step(0, 1, 1, 16'hFFFE, "R8");
    step(0, 1, 2, 16'h5A5A, "R8");
    step(1, 0, 1, 0, "R8");
    step(1, 0, 2, 0, "R8");
    step(0, 1, 1, 16'hFFFF, "R8");
    step(1, 0, 2, 0, "R8");
    step(1, 0, 1, 0, "R8");
    // R10 status slot
    step(0, 1, 3, 16'hFFFF, "R10");
    step(1, 0, 0, 0, "R10");
    step(1, 0, 1, 0, "R10");
    step(1, 0, 3, 0, "R10");
    // R11 simultaneous read and write
    step(1, 1, 1, 16'h0040, "R11");
    step(1, 1, 2, 16'h7777, "R11");
    step(1, 0, 1, 0, "R11");
    // R12 non-data accesses leave memory strobes low
    step(1, 0, 0, 0, "R12");
    step(0, 1, 0, 16'h8020, "R12");
    step(1, 0, 0, 0, "R5");
    finishRun();
  end

endmodule